// File: doc/BRIEF.md
# Circular Indication Queue Writer

The block stores each received request frame as a block in a circular queue held in byte-wide RAM. The queue is organised in 8-byte segments and spans from a begin segment up to, but not including, an end segment. Every block starts on a segment boundary with an 8-byte header. The payload follows from byte 8, and the next block starts on the segment after the last byte. When the end segment is reached, the queue continues at the begin segment.

The block owns two write pointers. The early pointer advances as soon as a frame ends without error and raises a pre-indication pulse, so a fast responder can act before the frame is formally indicated. The committed pointer catches up with the early pointer only on an indicate request and raises the indication pulse. The host owns the read pointer. One segment is always kept empty, so a full queue can be told apart from an empty one. A frame is refused at its start when its blocks would reach into that spare segment.

Both pointers are kept internally as offsets from the begin segment. After reset they therefore sit on the begin segment without being loaded.

Top module: `ind_queue_writer`

## Requirements
- R1: After reset, wp_pre_o and wp_o equal begin_seg_i, no pulse output is high, no RAM write is issued, and full_o is low while rd_seg_i equals begin_seg_i.
- R2: A queued block header holds these bytes at offsets 0 to 7 from the block's first segment: response pointer, status 0x00, payload length, source address, destination address, control octet, remote SAP, local SAP.
- R3: A frame with sap_ext_i low stores 0xFF at header offsets 6 and 7, whatever rsap_i and lsap_i carry.
- R4: Payload bytes are written in arrival order from block offset 8. A payload byte outside a frame, or beyond the stated length, is not written. A payload byte takes the RAM port in its own cycle, and any header byte still pending waits for a later free cycle.
- R5: When a frame ends without error, wp_pre_o advances by 1 + ceil(len/8) segments, and pre_irq_o is high for exactly the one cycle after the commit edge.
- R6: Segment addresses that reach end_seg_i continue at begin_seg_i. This applies to RAM writes and to both pointers.
- R7: A frame needing more segments than are free (queue size minus used minus one) is refused at its start. refuse_o pulses for one cycle, no RAM write is issued and wp_pre_o is unchanged.
- R8: A frame with payload length 0 and response pointer 0 is not queued: no RAM write, no pulse, no pointer change.
- R9: A frame that ends with frm_err_i high leaves wp_pre_o at its value before the frame and raises no pre_irq_o.
- R10: indicate_i copies the early pointer into wp_o, and ind_irq_o pulses in the next cycle. If the two pointers are already equal, nothing changes and no pulse is raised.
- R11: full_o is high exactly when no segment is free between the early write pointer and the read pointer, the spare segment excluded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| begin_seg_i | input | SEG_W | First segment of the queue |
| end_seg_i | input | SEG_W | First segment after the queue |
| rd_seg_i | input | SEG_W | Host read pointer (segment) |
| frm_start_i | input | 1 | Frame start; header fields valid |
| rsp_ptr_i | input | 8 | Response buffer pointer |
| len_i | input | 8 | Payload length in bytes |
| src_i | input | 8 | Source address |
| dst_i | input | 8 | Destination address |
| ctrl_i | input | 8 | Control octet |
| sap_ext_i | input | 1 | SAP extension present |
| rsap_i | input | 8 | Remote SAP |
| lsap_i | input | 8 | Local SAP |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_i | input | 8 | Payload byte |
| frm_end_i | input | 1 | Frame end |
| frm_err_i | input | 1 | Frame ended with error (with frm_end_i) |
| indicate_i | input | 1 | Make the indication |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | SEG_W+3 | RAM byte address |
| ram_data_o | output | 8 | RAM write data |
| wp_pre_o | output | SEG_W | Early write pointer |
| wp_o | output | SEG_W | Committed write pointer |
| pre_irq_o | output | 1 | Pre-indication pulse |
| ind_irq_o | output | 1 | Indication pulse |
| refuse_o | output | 1 | Frame refused for lack of space |
| full_o | output | 1 | No free segment |

## Verification
A payload byte reaches the RAM port in the cycle it is presented. The bench therefore captures writes at the rising edge that stores them. Header bytes fill the cycles in between, and the bench spaces payload bytes one idle cycle apart so that the header finishes before the frame end. refuse_o follows the sampled start edge by one cycle, and pre_irq_o and the new wp_pre_o follow the sampled end edge by one cycle. ind_irq_o and wp_o follow indicate_i by one cycle. The bench checks each of these at the falling edge right after that edge. The one exception is a frame whose end arrives before its header is complete: there the bench waits a bounded number of cycles for the pulse. full_o is combinational from the read pointer and is checked shortly after the read pointer changes.

// File: rtl/iqw_pkg.sv
`timescale 1ns/1ps
package iqw_pkg;
  localparam int HDR_BYTES = 8;
  localparam int OFF_W     = 3;
  localparam logic [7:0] STATUS_OK = 8'h00;
  localparam logic [7:0] NO_SAP    = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_FINISH, ST_DROP} iqw_state_e;

  typedef struct packed {
    logic [7:0] rsp;
    logic [7:0] len;
    logic [7:0] src;
    logic [7:0] dst;
    logic [7:0] ctrl;
    logic [7:0] rsap;
    logic [7:0] lsap;
  } iqw_hdr_t;
endpackage

// File: rtl/iqw_space.sv
`timescale 1ns/1ps
module iqw_space #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] begin_seg_i,
  input  logic [SEG_W-1:0] end_seg_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  input  logic [SEG_W-1:0] pre_off_i,
  input  logic [7:0]       len_i,
  output logic [SEG_W-1:0] size_o,
  output logic [SEG_W:0]   free_o,
  output logic [SEG_W:0]   need_o,
  output logic             full_o
);
  localparam logic [SEG_W:0] ONE = {{SEG_W{1'b0}}, 1'b1};

  logic [SEG_W-1:0] rd_off;
  logic [SEG_W:0]   used;
  logic [SEG_W:0]   pay_segs;

  assign size_o = end_seg_i - begin_seg_i;
  assign rd_off = rd_seg_i - begin_seg_i;

  always_comb begin
    if (pre_off_i >= rd_off) used = {1'b0, pre_off_i - rd_off};
    else                     used = {1'b0, pre_off_i} + {1'b0, size_o} - {1'b0, rd_off};
  end

  // one segment always stays empty
  assign free_o = {1'b0, size_o} - used - ONE;

  assign pay_segs = (SEG_W+1)'(len_i[7:3]) + ((|len_i[2:0]) ? ONE : '0);
  assign need_o   = ONE + pay_segs;
  assign full_o   = (free_o == '0);
endmodule

// File: rtl/iqw_wrap.sv
`timescale 1ns/1ps
module iqw_wrap #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] size_i,
  input  logic [SEG_W-1:0] base_off_i,
  input  logic [SEG_W:0]   delta_i,
  output logic [SEG_W-1:0] off_o
);
  logic [SEG_W:0] sum;
  logic           over;

  assign sum   = {1'b0, base_off_i} + delta_i;
  assign over  = (sum >= {1'b0, size_i});
  assign off_o = over ? (sum[SEG_W-1:0] - size_i) : sum[SEG_W-1:0];
endmodule

// File: rtl/iqw_hdr.sv
`timescale 1ns/1ps
module iqw_hdr
  import iqw_pkg::*;
(
  input  logic [OFF_W-1:0] idx_i,
  input  iqw_hdr_t         hdr_i,
  output logic [7:0]       byte_o
);
  // byte order is decoded by the consumer of the queue
  always_comb begin
    unique case (idx_i)
      3'd0:    byte_o = hdr_i.rsp;
      3'd1:    byte_o = STATUS_OK;
      3'd2:    byte_o = hdr_i.len;
      3'd3:    byte_o = hdr_i.src;
      3'd4:    byte_o = hdr_i.dst;
      3'd5:    byte_o = hdr_i.ctrl;
      3'd6:    byte_o = hdr_i.rsap;
      default: byte_o = hdr_i.lsap;
    endcase
  end
endmodule

// File: rtl/ind_queue_writer.sv
`timescale 1ns/1ps
module ind_queue_writer
  import iqw_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEG_W-1:0] begin_seg_i,
  input  logic [SEG_W-1:0] end_seg_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  input  logic             frm_start_i,
  input  logic [7:0]       rsp_ptr_i,
  input  logic [7:0]       len_i,
  input  logic [7:0]       src_i,
  input  logic [7:0]       dst_i,
  input  logic [7:0]       ctrl_i,
  input  logic             sap_ext_i,
  input  logic [7:0]       rsap_i,
  input  logic [7:0]       lsap_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             frm_end_i,
  input  logic             frm_err_i,
  input  logic             indicate_i,
  output logic             ram_we_o,
  output logic [SEG_W+2:0] ram_addr_o,
  output logic [7:0]       ram_data_o,
  output logic [SEG_W-1:0] wp_pre_o,
  output logic [SEG_W-1:0] wp_o,
  output logic             pre_irq_o,
  output logic             ind_irq_o,
  output logic             refuse_o,
  output logic             full_o
);
  localparam int SW1 = SEG_W + 1;
  localparam logic [SEG_W:0] ONE = {{SEG_W{1'b0}}, 1'b1};

  iqw_state_e       state_q;
  iqw_hdr_t         hdr_q, hdr_in;
  logic [SEG_W-1:0] start_off_q, pre_off_q, wp_off_q;
  logic [SEG_W:0]   need_q;
  logic [3:0]       hdr_idx_q;
  logic [7:0]       pidx_q;
  logic             pre_irq_q, ind_irq_q, refuse_q;

  logic [SEG_W-1:0] size;
  logic [SEG_W:0]   free, need;
  logic             pay_wr, hdr_wr, hdr_done, commit, skip;
  logic [SEG_W:0]   wr_delta;
  logic [SEG_W-1:0] wr_off, commit_off;
  logic [2:0]       byte_off;
  logic [7:0]       hdr_byte;

  iqw_space #(.SEG_W(SEG_W)) u_space (
    .begin_seg_i (begin_seg_i),
    .end_seg_i   (end_seg_i),
    .rd_seg_i    (rd_seg_i),
    .pre_off_i   (pre_off_q),
    .len_i       (len_i),
    .size_o      (size),
    .free_o      (free),
    .need_o      (need),
    .full_o      (full_o)
  );

  iqw_wrap #(.SEG_W(SEG_W)) u_wr_wrap (
    .size_i     (size),
    .base_off_i (start_off_q),
    .delta_i    (wr_delta),
    .off_o      (wr_off)
  );

  iqw_wrap #(.SEG_W(SEG_W)) u_commit_wrap (
    .size_i     (size),
    .base_off_i (start_off_q),
    .delta_i    (need_q),
    .off_o      (commit_off)
  );

  iqw_hdr u_hdr (
    .idx_i  (hdr_idx_q[2:0]),
    .hdr_i  (hdr_q),
    .byte_o (hdr_byte)
  );

  always_comb begin
    hdr_in.rsp  = rsp_ptr_i;
    hdr_in.len  = len_i;
    hdr_in.src  = src_i;
    hdr_in.dst  = dst_i;
    hdr_in.ctrl = ctrl_i;
    hdr_in.rsap = sap_ext_i ? rsap_i : NO_SAP;
    hdr_in.lsap = sap_ext_i ? lsap_i : NO_SAP;
  end

  assign skip     = (len_i == 8'd0) && (rsp_ptr_i == 8'd0);
  assign hdr_done = hdr_idx_q[3];

  // payload byte owns the RAM port in its cycle; header fills the gaps
  assign pay_wr = (state_q == ST_RECV) && byte_valid_i && (pidx_q < hdr_q.len);
  assign hdr_wr = ((state_q == ST_RECV) || (state_q == ST_FINISH)) && !pay_wr && !hdr_done;

  always_comb begin
    if (pay_wr) begin
      wr_delta   = ONE + SW1'(pidx_q[7:3]);
      byte_off   = pidx_q[2:0];
      ram_data_o = byte_i;
    end else begin
      wr_delta   = '0;
      byte_off   = hdr_idx_q[2:0];
      ram_data_o = hdr_byte;
    end
  end

  assign ram_we_o   = pay_wr || hdr_wr;
  assign ram_addr_o = {begin_seg_i + wr_off, byte_off};

  assign commit = hdr_done &&
                  (((state_q == ST_RECV) && frm_end_i && !frm_err_i) ||
                   (state_q == ST_FINISH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      hdr_q       <= '0;
      start_off_q <= '0;
      pre_off_q   <= '0;
      wp_off_q    <= '0;
      need_q      <= '0;
      hdr_idx_q   <= '0;
      pidx_q      <= '0;
      pre_irq_q   <= 1'b0;
      ind_irq_q   <= 1'b0;
      refuse_q    <= 1'b0;
    end else begin
      pre_irq_q <= 1'b0;
      ind_irq_q <= 1'b0;
      refuse_q  <= 1'b0;

      if (pay_wr) pidx_q    <= pidx_q + 8'd1;
      if (hdr_wr) hdr_idx_q <= hdr_idx_q + 4'd1;

      unique case (state_q)
        ST_IDLE: begin
          if (frm_start_i) begin
            hdr_q       <= hdr_in;
            start_off_q <= pre_off_q;
            need_q      <= need;
            hdr_idx_q   <= '0;
            pidx_q      <= '0;
            if (skip)               state_q  <= ST_DROP;
            else if (need <= free)  state_q  <= ST_RECV;
            else                    refuse_q <= 1'b1;
          end
        end
        ST_RECV: begin
          if (frm_end_i) begin
            if (frm_err_i)     state_q <= ST_IDLE;
            else if (hdr_done) state_q <= ST_IDLE;
            else               state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          if (hdr_done) state_q <= ST_IDLE;
        end
        default: begin
          if (frm_end_i) state_q <= ST_IDLE;
        end
      endcase

      if (commit) begin
        pre_off_q <= commit_off;
        pre_irq_q <= 1'b1;
      end

      if (indicate_i && (wp_off_q != pre_off_q)) begin
        wp_off_q  <= pre_off_q;
        ind_irq_q <= 1'b1;
      end
    end
  end

  assign wp_pre_o  = begin_seg_i + pre_off_q;
  assign wp_o      = begin_seg_i + wp_off_q;
  assign pre_irq_o = pre_irq_q;
  assign ind_irq_o = ind_irq_q;
  assign refuse_o  = refuse_q;
endmodule

// File: rtl/ind_queue_writer_chk.sv
`timescale 1ns/1ps
module ind_queue_writer_chk #(
  parameter int SEG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEG_W-1:0] begin_seg_i,
  input logic [SEG_W-1:0] end_seg_i,
  input logic             ram_we_o,
  input logic [SEG_W+2:0] ram_addr_o,
  input logic [SEG_W-1:0] wp_pre_o,
  input logic [SEG_W-1:0] wp_o,
  input logic             pre_irq_o,
  input logic             ind_irq_o,
  input logic             refuse_o
);
  // R10
  wp_moves_only_on_ind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ind_irq_o |-> $stable(wp_o));

  // R5
  pre_moves_only_on_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_irq_o |-> $stable(wp_pre_o));

  // R5
  pre_irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_irq_o |=> !pre_irq_o);

  // R6
  ram_in_queue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o[SEG_W+2:3] >= begin_seg_i) && (ram_addr_o[SEG_W+2:3] < end_seg_i));

  // R6
  wp_in_queue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_o >= begin_seg_i) && (wp_o < end_seg_i) &&
    (wp_pre_o >= begin_seg_i) && (wp_pre_o < end_seg_i));

  // R7
  refuse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_o |-> !pre_irq_o);
endmodule

bind ind_queue_writer ind_queue_writer_chk #(.SEG_W(SEG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .begin_seg_i (begin_seg_i),
  .end_seg_i   (end_seg_i),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .wp_pre_o    (wp_pre_o),
  .wp_o        (wp_o),
  .pre_irq_o   (pre_irq_o),
  .ind_irq_o   (ind_irq_o),
  .refuse_o    (refuse_o)
);

// File: tb/ind_queue_writer_bench.sv
`timescale 1ns/1ps
module ind_queue_writer_bench;
  localparam int SEG_W = 8;
  localparam int BEG   = 10;
  localparam int ENDS  = 30;
  localparam int SIZE  = ENDS - BEG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SEG_W-1:0] begin_seg = SEG_W'(BEG);
  logic [SEG_W-1:0] end_seg   = SEG_W'(ENDS);
  logic [SEG_W-1:0] rd_seg    = SEG_W'(BEG);
  logic frm_start = 0, sap_ext = 0, byte_valid = 0, frm_end = 0, frm_err = 0, indicate = 0;
  logic [7:0] rsp_ptr = 0, len = 0, src = 0, dst = 0, ctrl = 0, rsap = 0, lsap = 0, bdat = 0;
  logic ram_we, pre_irq, ind_irq, refuse, full;
  logic [SEG_W+2:0] ram_addr;
  logic [7:0] ram_data;
  logic [SEG_W-1:0] wp_pre, wp;

  always #5 clk = ~clk;

  ind_queue_writer #(.SEG_W(SEG_W)) u_ind_queue_writer (
    .clk_i(clk), .rst_ni(rst_n), .begin_seg_i(begin_seg), .end_seg_i(end_seg),
    .rd_seg_i(rd_seg), .frm_start_i(frm_start), .rsp_ptr_i(rsp_ptr), .len_i(len),
    .src_i(src), .dst_i(dst), .ctrl_i(ctrl), .sap_ext_i(sap_ext), .rsap_i(rsap),
    .lsap_i(lsap), .byte_valid_i(byte_valid), .byte_i(bdat), .frm_end_i(frm_end),
    .frm_err_i(frm_err), .indicate_i(indicate), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_data_o(ram_data), .wp_pre_o(wp_pre), .wp_o(wp), .pre_irq_o(pre_irq),
    .ind_irq_o(ind_irq), .refuse_o(refuse), .full_o(full)
  );

  logic [7:0] cap [0:2047];
  int wr_cnt = 0;
  always @(posedge clk) if (rst_n && ram_we) begin
    cap[ram_addr] <= ram_data;
    wr_cnt <= wr_cnt + 1;
  end

  int chk_cnt = 0, err_cnt = 0;
  int m_pre = 0, m_wp = 0, rd_off = 0;
  logic [7:0] pay [0:255];
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    chk_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int m_free();
    int used = (m_pre - rd_off + SIZE) % SIZE;
    return SIZE - 1 - used;
  endfunction

  function automatic int exp_addr(int start, int k);
    int seg = (start + k / 8) % SIZE;
    return ((BEG + seg) * 8) + (k % 8);
  endfunction

  task automatic send_frame(input int f_rsp, input int f_len, input bit f_ext,
                            input bit f_err, input bit short_end);
    int need, start, w0, cyc;
    bit skip, acc, got, wraps;
    logic [7:0] hb [0:7];
    skip  = (f_len == 0) && (f_rsp == 0);
    need  = 1 + (f_len + 7) / 8;
    acc   = !skip && (need <= m_free());
    start = m_pre;
    wraps = (start + need) > SIZE;
    for (int i = 0; i < f_len + 2; i++) pay[i] = 8'($urandom);
    w0 = wr_cnt;
    @(negedge clk);
    frm_start = 1; rsp_ptr = 8'(f_rsp); len = 8'(f_len); sap_ext = f_ext;
    src = 8'($urandom); dst = 8'($urandom); ctrl = 8'($urandom);
    rsap = 8'($urandom); lsap = 8'($urandom);
    hb[0] = rsp_ptr; hb[1] = 8'h00; hb[2] = len; hb[3] = src; hb[4] = dst; hb[5] = ctrl;
    hb[6] = f_ext ? rsap : 8'hFF; hb[7] = f_ext ? lsap : 8'hFF;
    @(negedge clk);
    check("R7 refuse", int'(refuse), int'(!skip && !acc));
    frm_start = 0;
    cyc = 1;
    if (!skip) begin
      for (int i = 0; i < f_len + 2; i++) begin
        byte_valid = 1; bdat = pay[i];
        @(negedge clk); byte_valid = 0; cyc++;
        @(negedge clk); cyc++;
      end
    end
    if (!short_end) while (cyc < 20) begin @(negedge clk); cyc++; end
    frm_end = 1; frm_err = f_err;
    @(negedge clk);
    frm_end = 0; frm_err = 0;
    if (!short_end) begin
      check(f_err ? "R9 pre_irq" : "R5 pre_irq", int'(pre_irq), int'(acc && !f_err));
    end else begin
      got = pre_irq;
      for (int t = 0; t < 15 && !got; t++) begin @(negedge clk); got = pre_irq; end
      check("R5 late header pre_irq", int'(got), int'(acc && !f_err));
    end
    if (acc && !f_err) m_pre = (start + need) % SIZE;
    check(f_err ? "R9 wp_pre" : (wraps ? "R6 wp_pre" : "R5 wp_pre"), int'(wp_pre), BEG + m_pre);
    check(skip ? "R8 writes" : (acc ? "R4 writes" : "R7 writes"), wr_cnt - w0, acc ? 8 + f_len : 0);
    if (acc && !f_err) begin
      for (int k = 0; k < 8 + f_len; k++) begin
        int ea = exp_addr(start, k);
        if (k < 6)      check("R2 header", int'(cap[ea]), int'(hb[k]));
        else if (k < 8) check(f_ext ? "R2 sap" : "R3 sap", int'(cap[ea]), int'(hb[k]));
        else            check(wraps ? "R6 payload" : "R4 payload", int'(cap[ea]), int'(pay[k-8]));
      end
    end
  endtask

  task automatic do_ind();
    bit exp_irq = (m_wp != m_pre);
    @(negedge clk); indicate = 1;
    @(negedge clk); indicate = 0;
    check("R10 ind_irq", int'(ind_irq), int'(exp_irq));
    m_wp = m_pre;
    check("R10 wp", int'(wp), BEG + m_wp);
  endtask

  task automatic set_rd(input int off);
    @(negedge clk);
    rd_seg = SEG_W'(BEG + off); rd_off = off;
    #1;
    check("R11 full", int'(full), int'(m_free() == 0));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt + 1, err_cnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 wp_pre", int'(wp_pre), BEG);
    check("R1 wp", int'(wp), BEG);
    check("R1 pulses", int'({pre_irq, ind_irq, refuse}), 0);
    check("R1 full", int'(full), 0);
    check("R1 writes", wr_cnt, 0);

    // bytes outside a frame
    @(negedge clk); byte_valid = 1; bdat = 8'h5A;
    @(negedge clk); byte_valid = 0;
    check("R4 idle byte", wr_cnt, 0);

    send_frame(0, 0, 1, 0, 0);      // R8
    send_frame(5, 0, 1, 0, 1);      // R5 end before header done
    send_frame(3, 9, 0, 0, 0);      // R3
    send_frame(7, 17, 1, 1, 0);     // R9
    do_ind();
    do_ind();                       // R10 no change
    send_frame(9, 30, 1, 0, 0);
    // fill to full
    for (int i = 0; i < 25 && m_free() > 0; i++) send_frame(1, (m_free() > 2) ? 12 : 0, 1, 0, 0);
    check("R11 full at limit", int'(full), 1);
    send_frame(1, 0, 1, 0, 0);      // R7 refused
    do_ind();
    set_rd(m_wp);

    for (int it = 0; it < 60; it++) begin
      int l = int'($urandom % 48);
      int r = ($urandom % 4 == 0) ? 0 : int'($urandom % 256);
      send_frame(r, l, bit'($urandom % 2), ($urandom % 8) == 0, 0);
      if ($urandom % 2 == 0) do_ind();
      if ($urandom % 3 == 0) set_rd(m_wp);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, err_cnt);
    $finish;
  end
endmodule